// File: doc/BRIEF.md
# Instruction fetch burst sequencer

This block fetches script instructions for a DMA script engine. Each instruction is two, three or four 32-bit words long. The block reads these words from system memory through a small bus-master port that can ask for a burst of words. Once it has all the words of one instruction, it hands them, with their count, to the decode stage over a valid/ready handshake. When decode accepts them, it goes straight on to fetch the instruction at the next address.

A configuration bit turns on burst fetching. With burst fetching on, the first two words of every instruction come in one bus ownership. The word count is then known from the first word, and any words that remain are requested in one later ownership. With burst fetching off, every word is a separate single-word ownership. There are two bypass inputs: one says that prefetching is active, the other that the fetch is being served from on-chip instruction RAM. When either of them is high, the burst setting is overridden and words are fetched one at a time.

Software starts the block by writing a start address. A manual-start bit chooses what that write does. With manual start cleared, the write launches fetching at once. With manual start set, the write only loads the address, and fetching waits for a separate start strobe.

Top module: `insn_fetch_seq`

## Requirements
- R1: The instruction length comes from the first word. If bits [31:30] are 2'b11, the length is 3 words. If bits [31:30] are 2'b00, the length is 4 words when bit 28 is set, else 3 words when bit 29 is set, else 2 words. Any other value of bits [31:30] gives 2 words, whatever bits 29 and 28 hold. The length is presented on `insnLen`.
- R2: With burst effective, the first ownership of each instruction asks for 2 beats at the instruction's first address. Burst is effective when `cfgBurst`=1, `cfgPrefetch`=0 and `ramHit`=0.
- R3: With burst effective, an instruction longer than 2 words gets exactly one more ownership. That ownership asks for length-2 beats at the instruction address + 8.
- R4: With `cfgBurst`=0, each word is its own ownership with `busBeats`=1, and the addresses rise by 4.
- R5: When `cfgPrefetch` or `ramHit` is 1, `cfgBurst` has no effect, and fetching uses single-word ownerships as in R4.
- R6: With `cfgManual`=1, writing the start address loads it but does not raise `busReq`. A one-cycle pulse on `startStrobe` then starts fetching at the loaded address.
- R7: With `cfgManual`=0, writing the start address in idle starts fetching at that address on the next cycle.
- R8: Each word received moves the fetch address on by 4. The next instruction is requested only after `insnReady` accepts the current one, and it starts at the current address + 4 × length.
- R9: While `insnValid` is high and `insnReady` is low, `insnValid`, `insnWords` and `insnLen` hold steady, and no bus request is made.
- R10: A data beat with `busRdErr` set aborts the fetch. It sets `fetchErr` and returns to idle with `busReq` low. `fetchErr` stays set until the next start address write clears it.
- R11: During and straight after reset, `busReq`, `insnValid` and `fetchErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBurst | input | 1 | Burst fetch enable |
| cfgPrefetch | input | 1 | Prefetch active; overrides burst fetch |
| ramHit | input | 1 | Fetch served from on-chip RAM; overrides burst fetch |
| cfgManual | input | 1 | Manual start mode |
| startAddrWr | input | 1 | Start address write strobe |
| startAddr | input | 32 | Start address value |
| startStrobe | input | 1 | Explicit start pulse |
| busReq | output | 1 | Bus ownership request |
| busAddr | output | 32 | First byte address of the ownership |
| busBeats | output | 2 | Number of words in the ownership (1 or 2) |
| busGnt | input | 1 | Request accepted |
| busRdValid | input | 1 | Read data beat valid |
| busRdData | input | 32 | Read data word |
| busRdErr | input | 1 | Error response on this beat |
| insnValid | output | 1 | Assembled instruction valid |
| insnReady | input | 1 | Decode stage accepts the instruction |
| insnWords | output | 128 | Instruction words; word k at bits [32k+31:32k] |
| insnLen | output | 3 | Instruction length in words |
| fetchErr | output | 1 | Sticky bus error flag |

## Verification
The assertions are checked on every cycle. They cover these behaviours:
- Words are fetched one at a time whenever burst fetch is off or overridden.
- An instruction stays stable while decode stalls.
- A bus error forces the block back to idle.
- In manual mode, an address write on its own does not start fetching.
- Each received word moves the address on by 4.
- The delivered length is always between 2 and 4.

Only the bench scenarios can show the following: that the grouping of words into ownerships matches each instruction type, that the assembled words come from the right addresses, that the next instruction follows at the right place, and that an error flag is cleared by the next address write.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_DATA,
    S_DELIVER
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPc;
    logic clrErr;
    logic setErr;
    logic takeBeat;
    logic armBeats;
    logic clrIdx;
  } seqCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic lastBeat;
    logic insnDone;
  } seqStat_t;

  // Length in words from the first instruction word
  function automatic logic [2:0] insnLenOf(input logic [31:0] w0);
    logic [2:0] len;
    len = 3'd2;
    if (w0[31:30] == 2'b11) begin
      len = 3'd3;
    end else if (w0[31:30] == 2'b00) begin
      if (w0[28])      len = 3'd4;
      else if (w0[29]) len = 3'd3;
    end
    return len;
  endfunction

endpackage

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_WORDS  = 4,
  parameter int HEAD_BEATS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCtl_t                       ctl,
  input  logic [ADDR_W-1:0]             startAddr,
  input  logic [DATA_W-1:0]             busRdData,
  input  logic                          burstEff,
  output logic [ADDR_W-1:0]             pc,
  output logic [$clog2(HEAD_BEATS+1)-1:0] beatsReq,
  output logic [MAX_WORDS*DATA_W-1:0]   insnWords,
  output logic [$clog2(MAX_WORDS+1)-1:0] insnLen,
  output logic                          fetchErr,
  output seqStat_t                      stat
);

  localparam int IDX_W  = $clog2(MAX_WORDS + 1);
  localparam int BEAT_W = $clog2(HEAD_BEATS + 1);
  localparam int STEP   = DATA_W / 8;

  logic [IDX_W-1:0]  wordIdx;
  logic [BEAT_W-1:0] beatsLeft;
  logic [IDX_W-1:0]  remain;
  logic [DATA_W-1:0] wordMem [MAX_WORDS];

  // Fetch address
  always_ff @(posedge clk) begin
    if (!rstN)              pc <= '0;
    else if (ctl.loadPc)    pc <= startAddr;
    else if (ctl.takeBeat)  pc <= pc + ADDR_W'(STEP);
  end

  // Word slot index within the current instruction
  always_ff @(posedge clk) begin
    if (!rstN)              wordIdx <= '0;
    else if (ctl.clrIdx)    wordIdx <= '0;
    else if (ctl.takeBeat)  wordIdx <= wordIdx + 1'b1;
  end

  // Length latched from the first word
  always_ff @(posedge clk) begin
    if (!rstN) insnLen <= IDX_W'(2);
    else if (ctl.takeBeat && wordIdx == '0)
      insnLen <= IDX_W'(insnLenOf(busRdData[31:0]));
  end

  // Ownership size: head burst, remainder burst, or one word
  assign remain = insnLen - wordIdx;
  always_comb begin
    if (!burstEff)           beatsReq = BEAT_W'(1);
    else if (wordIdx == '0)  beatsReq = BEAT_W'(HEAD_BEATS);
    else                     beatsReq = remain[BEAT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              beatsLeft <= '0;
    else if (ctl.armBeats)  beatsLeft <= beatsReq;
    else if (ctl.takeBeat)  beatsLeft <= beatsLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            fetchErr <= 1'b0;
    else if (ctl.setErr)  fetchErr <= 1'b1;
    else if (ctl.clrErr)  fetchErr <= 1'b0;
  end

  // Word capture, one slot per instruction word
  for (genvar g = 0; g < MAX_WORDS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) wordMem[g] <= '0;
      else if (ctl.takeBeat && wordIdx == IDX_W'(g)) wordMem[g] <= busRdData;
    end
    assign insnWords[g*DATA_W +: DATA_W] = wordMem[g];
  end

  assign stat.lastBeat = (beatsLeft == BEAT_W'(1));
  assign stat.insnDone = (wordIdx != '0) && (wordIdx + 1'b1 == insnLen);

  // R8: each accepted word moves the address by one word
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeBeat |=> pc == $past(pc) + ADDR_W'(STEP));

endmodule

// File: rtl/fetch_seq_ctl.sv
module fetch_seq_ctl
  import fetch_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgManual,
  input  logic     startAddrWr,
  input  logic     startStrobe,
  input  logic     busGnt,
  input  logic     busRdValid,
  input  logic     busRdErr,
  input  logic     insnReady,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     busReq,
  output logic     insnValid
);

  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      S_IDLE: begin
        if (startAddrWr) begin
          ctl.loadPc = 1'b1;
          ctl.clrErr = 1'b1;
        end
        if (startStrobe || (startAddrWr && !cfgManual)) begin
          ctl.clrIdx = 1'b1;
          nxt        = S_REQ;
        end
      end
      S_REQ: begin
        if (busGnt) begin
          ctl.armBeats = 1'b1;
          nxt          = S_DATA;
        end
      end
      S_DATA: begin
        if (busRdValid) begin
          if (busRdErr) begin
            ctl.setErr = 1'b1;
            nxt        = S_IDLE;
          end else begin
            ctl.takeBeat = 1'b1;
            if (stat.insnDone)      nxt = S_DELIVER;
            else if (stat.lastBeat) nxt = S_REQ;
          end
        end
      end
      S_DELIVER: begin
        if (insnReady) begin
          ctl.clrIdx = 1'b1;
          nxt        = S_REQ;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busReq    = (state == S_REQ);
  assign insnValid = (state == S_DELIVER);

  // R6: a bare address write in manual mode does not start fetching
  a_r6_manual_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startAddrWr && cfgManual && !startStrobe) |=> !busReq);

  // R10: an error beat returns the sequencer to idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && busRdValid && busRdErr) |=> (!busReq && !insnValid));

endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_WORDS  = 4,
  parameter int HEAD_BEATS = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgBurst,
  input  logic                            cfgPrefetch,
  input  logic                            ramHit,
  input  logic                            cfgManual,
  input  logic                            startAddrWr,
  input  logic [ADDR_W-1:0]               startAddr,
  input  logic                            startStrobe,
  output logic                            busReq,
  output logic [ADDR_W-1:0]               busAddr,
  output logic [$clog2(HEAD_BEATS+1)-1:0] busBeats,
  input  logic                            busGnt,
  input  logic                            busRdValid,
  input  logic [DATA_W-1:0]               busRdData,
  input  logic                            busRdErr,
  output logic                            insnValid,
  input  logic                            insnReady,
  output logic [MAX_WORDS*DATA_W-1:0]     insnWords,
  output logic [$clog2(MAX_WORDS+1)-1:0]  insnLen,
  output logic                            fetchErr
);

  seqCtl_t  ctl;
  seqStat_t stat;
  logic     burstEff;

  assign burstEff = cfgBurst && !cfgPrefetch && !ramHit;

  fetch_seq_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgManual  (cfgManual),
    .startAddrWr(startAddrWr),
    .startStrobe(startStrobe),
    .busGnt     (busGnt),
    .busRdValid (busRdValid),
    .busRdErr   (busRdErr),
    .insnReady  (insnReady),
    .stat       (stat),
    .ctl        (ctl),
    .busReq     (busReq),
    .insnValid  (insnValid)
  );

  fetch_seq_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_WORDS (MAX_WORDS),
    .HEAD_BEATS(HEAD_BEATS)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(startAddr),
    .busRdData(busRdData),
    .burstEff (burstEff),
    .pc       (busAddr),
    .beatsReq (busBeats),
    .insnWords(insnWords),
    .insnLen  (insnLen),
    .fetchErr (fetchErr),
    .stat     (stat)
  );

  // R4 / R5: single-word ownerships whenever burst is off or overridden
  a_r4_single_beat: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && (!cfgBurst || cfgPrefetch || ramHit)) |-> busBeats == 1);

  // R9: a stalled instruction is held unchanged
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && !insnReady) |=> (insnValid && $stable(insnWords) && $stable(insnLen)));

  // R1: delivered length is always a legal instruction size
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rstN)
    insnValid |-> (insnLen >= 2 && insnLen <= MAX_WORDS));

endmodule

// File: tb/insn_fetch_seq_test.sv
module insn_fetch_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [31:0] w0;
    logic        burst;
    logic        pf;
    logic        ram;
    logic [2:0]  len;
  } vec_t;

  // word0, burst, prefetch, ramHit, expected length (per R1)
  localparam vec_t VECS [NVEC] = '{
    '{32'h0800_0010, 1'b1, 1'b0, 1'b0, 3'd2},
    '{32'hC000_0004, 1'b1, 1'b0, 1'b0, 3'd3},
    '{32'h2000_0008, 1'b1, 1'b0, 1'b0, 3'd3},
    '{32'h1000_0000, 1'b1, 1'b0, 1'b0, 3'd4},
    '{32'h3000_0000, 1'b1, 1'b0, 1'b0, 3'd4},
    '{32'h6000_0000, 1'b1, 1'b0, 1'b0, 3'd2},
    '{32'h9000_0000, 1'b0, 1'b0, 1'b0, 3'd2},
    '{32'h1000_0000, 1'b0, 1'b0, 1'b0, 3'd4},
    '{32'hC000_0000, 1'b1, 1'b1, 1'b0, 3'd3},
    '{32'h1000_0000, 1'b1, 1'b0, 1'b1, 3'd4},
    '{32'h2000_0000, 1'b0, 1'b0, 1'b0, 3'd3}
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic         cfgBurst, cfgPrefetch, ramHit, cfgManual;
  logic         startAddrWr, startStrobe;
  logic [31:0]  startAddr;
  logic         busReq;
  logic [31:0]  busAddr;
  logic [1:0]   busBeats;
  logic         busGnt, busRdValid, busRdErr;
  logic [31:0]  busRdData;
  logic         insnValid, insnReady;
  logic [127:0] insnWords;
  logic [2:0]   insnLen;
  logic         fetchErr;

  int compCnt = 0;
  int misCnt  = 0;

  // memory model state
  logic [31:0] curBase, curWord0, errAddr;
  int          ownCount;
  logic [31:0] ownAddr [8];
  logic [1:0]  ownBeats [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_fetch_seq uut (
    .clk(clk), .rstN(rstN), .cfgBurst(cfgBurst), .cfgPrefetch(cfgPrefetch),
    .ramHit(ramHit), .cfgManual(cfgManual), .startAddrWr(startAddrWr),
    .startAddr(startAddr), .startStrobe(startStrobe), .busReq(busReq),
    .busAddr(busAddr), .busBeats(busBeats), .busGnt(busGnt),
    .busRdValid(busRdValid), .busRdData(busRdData), .busRdErr(busRdErr),
    .insnValid(insnValid), .insnReady(insnReady), .insnWords(insnWords),
    .insnLen(insnLen), .fetchErr(fetchErr)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a == curBase) ? curWord0 : {16'hD00D, a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    compCnt++;
    if (!ok) begin
      misCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeStart(input logic [31:0] a);
    startAddrWr = 1'b1;
    startAddr   = a;
    @(negedge clk);
    startAddrWr = 1'b0;
  endtask

  task automatic waitValid();
    while (!insnValid) @(negedge clk);
  endtask

  task automatic waitErr();
    while (!(fetchErr && !busReq)) @(negedge clk);
  endtask

  // bus responder: grant, then stream beats; error on errAddr
  initial begin
    busGnt = 1'b0; busRdValid = 1'b0; busRdErr = 1'b0; busRdData = '0;
    forever begin
      @(negedge clk);
      if (busReq) begin
        logic [31:0] a;
        int          n;
        a = busAddr;
        n = int'(busBeats);
        if (ownCount < 8) begin
          ownAddr[ownCount]  = a;
          ownBeats[ownCount] = busBeats;
        end
        ownCount++;
        busGnt = 1'b1;
        @(negedge clk);
        busGnt = 1'b0;
        for (int b = 0; b < n; b++) begin
          busRdValid = 1'b1;
          busRdErr   = (a == errAddr);
          busRdData  = memWord(a);
          @(negedge clk);
          if (busRdErr) break;
          a = a + 32'd4;
        end
        busRdValid = 1'b0;
        busRdErr   = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    misCnt++;
    compCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compCnt, misCnt);
    $finish;
  end

  initial begin
    logic [31:0] base;
    logic [127:0] held;
    bit burstEff;
    int expOwn;
    bit ok;

    rstN = 1'b0; cfgBurst = 1'b0; cfgPrefetch = 1'b0; ramHit = 1'b0;
    cfgManual = 1'b0; startAddrWr = 1'b0; startAddr = '0; startStrobe = 1'b0;
    insnReady = 1'b1; ownCount = 0;
    curBase = 32'hFFFF_FFF0; curWord0 = '0; errAddr = 32'hFFFF_FFFF;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(!busReq && !insnValid && !fetchErr, "R11", "during reset",
        {busReq, insnValid, fetchErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busReq && !insnValid && !fetchErr, "R11", "after reset",
        {busReq, insnValid, fetchErr}, 0);

    // table of instruction types and fetch modes
    for (int i = 0; i < NVEC; i++) begin
      base     = 32'h1000 + 32'(i) * 32'h100;
      curBase  = base;
      curWord0 = VECS[i].w0;
      errAddr  = base + 32'(VECS[i].len) * 4;
      cfgBurst = VECS[i].burst;
      cfgPrefetch = VECS[i].pf;
      ramHit   = VECS[i].ram;
      burstEff = VECS[i].burst && !VECS[i].pf && !VECS[i].ram;
      expOwn   = burstEff ? ((VECS[i].len > 2) ? 2 : 1) : int'(VECS[i].len);
      ownCount = 0;
      writeStart(base);
      chk(!fetchErr, "R10", "flag cleared by address write", fetchErr, 0);
      waitValid();

      chk(insnLen == VECS[i].len, "R1", "length", insnLen, VECS[i].len);

      ok = 1'b1;
      for (int k = 0; k < int'(VECS[i].len); k++)
        if (insnWords[k*32 +: 32] != memWord(base + 32'(k) * 4)) ok = 1'b0;
      chk(ok, "R8", "assembled words", insnWords, {memWord(base + 4), VECS[i].w0});

      chk(ownCount >= 1 && ownAddr[0] == base, "R7", "auto start address",
          ownAddr[0], base);
      chk(ownCount == expOwn, burstEff ? "R2" : (VECS[i].burst ? "R5" : "R4"),
          "ownership count", ownCount, expOwn);

      ok = 1'b1;
      for (int k = 0; k < expOwn && k < 8; k++) begin
        logic [31:0] ea;
        logic [1:0]  eb;
        if (burstEff) begin
          ea = (k == 0) ? base : base + 8;
          eb = (k == 0) ? 2'd2 : 2'(VECS[i].len - 3'd2);
        end else begin
          ea = base + 32'(k) * 4;
          eb = 2'd1;
        end
        if (ownAddr[k] != ea || ownBeats[k] != eb) ok = 1'b0;
      end
      chk(ok, burstEff ? "R3" : (VECS[i].burst ? "R5" : "R4"),
          "ownership addresses and beats",
          {ownAddr[0], 6'd0, ownBeats[0], ownAddr[1], 6'd0, ownBeats[1]}, base);

      waitErr();
      chk(ownCount == expOwn + 1 && ownAddr[expOwn] == errAddr, "R8",
          "next instruction address", ownAddr[expOwn], errAddr);
      chk(fetchErr && !busReq && !insnValid, "R10", "abort to idle",
          {fetchErr, busReq, insnValid}, 3'b100);
    end

    // R6: manual start
    cfgManual = 1'b1; cfgBurst = 1'b1; cfgPrefetch = 1'b0; ramHit = 1'b0;
    base = 32'h3000; curBase = base; curWord0 = 32'h0800_0000;
    errAddr = base + 8; ownCount = 0;
    writeStart(base);
    repeat (6) @(negedge clk);
    chk(!busReq && ownCount == 0, "R6", "address write alone does not start",
        ownCount, 0);
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    waitValid();
    chk(ownAddr[0] == base && insnLen == 3'd2, "R6", "strobe starts at loaded address",
        ownAddr[0], base);
    waitErr();
    cfgManual = 1'b0;

    // R9: decode stall holds the instruction
    base = 32'h4000; curBase = base; curWord0 = 32'h1000_0000;
    errAddr = base + 16; ownCount = 0; insnReady = 1'b0;
    writeStart(base);
    waitValid();
    held = insnWords;
    repeat (4) @(negedge clk);
    chk(insnValid && insnWords == held && insnLen == 3'd4, "R9", "held under stall",
        insnWords, held);
    chk(!busReq && ownCount == 2, "R9", "no request while stalled", ownCount, 2);
    insnReady = 1'b1;
    waitErr();
    chk(ownAddr[2] == base + 16, "R8", "fetch resumes after accept", ownAddr[2], base + 16);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compCnt, misCnt);
    $finish;
  end

endmodule